// File: doc/BRIEF.md
# Nibble-Wide Multiplexed Register Port

This block gives a small peripheral a host-facing port onto sixteen 4-bit storage registers. It follows the style of a microcontroller bus. A 4-bit address is captured under an address-latch-enable strobe. Data moves over a 4-bit port that the bench and the pad ring see as three signals: input data, output data and an output enable. Active-low write and read strobes start the transfers. Two chip selects of opposite polarity qualify them: `cs0_ni` is active low and gates the address latch as well as the transfers, while `cs1_i` is active high and gates only the transfers.

All logic runs on one system clock. The write, read and latch-enable strobes pass through two-flop synchronisers. A write commits when the write strobe returns high, which the block finds as a rising edge of the synchronised strobe. The address used is the one held in the latch at that moment. If the read and write strobes are low together, the read is suppressed and the data port stays released.

The block also drives one open-drain status output, modelled as a pull-low enable. Bit 1 of register 0xD decides whether pulses on the external `tick_i` input appear on that output. The output does not depend on either chip select.

Top module: `nibble_reg_port`

## Requirements
- R1: After reset all sixteen registers read 0, `dout_oe_o` is 0, `dout_o` is 0 and `stat_pull_o` is 0.
- R2: While `ale_i`=1 and `cs0_ni`=0 the address latch follows `addr_i`. After `ale_i` falls it keeps the captured value, and later changes on `addr_i` do not affect which register is accessed.
- R3: While `cs0_ni`=1 the address latch ignores `addr_i`, even when `ale_i`=1.
- R4: When `wr_ni` rises while `cs1_i`=1 and `cs0_ni`=0, the value on `din_i` (bit 0 = LSB) is stored into the register at the latched address. It is readable once the synchroniser delay has passed (at most 4 clocks after the edge).
- R5: A write strobe has no effect on any register when `cs1_i`=0 or `cs0_ni`=1.
- R6: While `cs1_i`=1, `cs0_ni`=0 and `rd_ni`=0, once the synchroniser delay has passed (2 clocks), `dout_oe_o`=1 and `dout_o` carries the addressed register. Otherwise `dout_oe_o`=0 and `dout_o`=0.
- R7: While `rd_ni` and `wr_ni` are both 0, `dout_oe_o` stays 0.
- R8: `stat_pull_o` equals `tick_i` AND bit 1 of register 0xD, delayed by one clock, whatever the chip selects are.
- R9: With `ale_i` held at 1 and `cs0_ni`=0 the latch is transparent: each read or write uses the current `addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register address |
| ale_i | input | 1 | Address latch enable, active high |
| cs0_ni | input | 1 | Chip select, active low; gates the latch and transfers |
| cs1_i | input | 1 | Chip select, active high; gates transfers only |
| wr_ni | input | 1 | Write strobe, active low; commits on rising edge |
| rd_ni | input | 1 | Read strobe, active low |
| din_i | input | 4 | Write data, bit 0 = LSB |
| dout_o | output | 4 | Read data, 0 when not driven |
| dout_oe_o | output | 1 | Data port output enable |
| tick_i | input | 1 | Status pulse source |
| stat_pull_o | output | 1 | Open-drain status pull-low enable |

## Verification
A wrong latched address shows up on the first read after the latch enable falls: the data comes from a neighbouring register, or a write lands in the wrong one. Both can be seen within about four clocks of the read strobe. A write that commits when it should not shows up on the next read of that register. The sweep writes a distinct arithmetic pattern to every register and reads all sixteen back, so any mis-decode is caught. A wrong state in the status gate shows on `stat_pull_o` one clock after a tick.

// File: rtl/nibble_reg_pkg.sv
package nibble_reg_pkg;
  localparam int unsigned DATA_W    = 4;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned CTRL_ADDR = 13;
  localparam int unsigned CTRL_BIT  = 1;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/addr_latch.sv
module addr_latch #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic              cs0_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                addr_q <= '0;
    else if (ale_i && !cs0_ni)  addr_q <= addr_i;
  end
  assign addr_o = addr_q;

  AST_LATCH_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_i && !cs0_ni) |=> addr_o == $past(addr_i)) else $error("latch follow"); // R2
  AST_LATCH_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_i || cs0_ni) |=> $stable(addr_o)) else $error("latch hold"); // R3
endmodule

// File: rtl/reg_file.sv
module reg_file #(
  parameter int unsigned DATA_W    = 4,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned CTRL_ADDR = 13,
  parameter int unsigned CTRL_BIT  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ctrl_en_o
);
  localparam int unsigned NREGS = 1 << ADDR_W;

  logic [NREGS-1:0][DATA_W-1:0] mem_q;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[i] <= '0;
      else if (we_i && addr_i == ADDR_W'(i))       mem_q[i] <= wdata_i;
    end
  end

  assign rdata_o   = mem_q[addr_i];
  assign ctrl_en_o = mem_q[CTRL_ADDR][CTRL_BIT];

  AST_HOLD_NO_WE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q)) else $error("reg changed without write"); // R5
endmodule

// File: rtl/status_gate.sv
module status_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  output logic pull_o
);
  logic pull_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pull_q <= 1'b0;
    else         pull_q <= tick_i & en_i;
  end
  assign pull_o = pull_q;

  AST_STAT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_o) |-> $past(en_i) && $past(tick_i)) else $error("status leak"); // R8
endmodule

// File: rtl/nibble_reg_port.sv
module nibble_reg_port
  import nibble_reg_pkg::*;
#(
  parameter int unsigned P_DATA_W    = DATA_W,
  parameter int unsigned P_ADDR_W    = ADDR_W,
  parameter int unsigned P_CTRL_ADDR = CTRL_ADDR,
  parameter int unsigned P_CTRL_BIT  = CTRL_BIT
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [P_ADDR_W-1:0] addr_i,
  input  logic                ale_i,
  input  logic                cs0_ni,
  input  logic                cs1_i,
  input  logic                wr_ni,
  input  logic                rd_ni,
  input  logic [P_DATA_W-1:0] din_i,
  output logic [P_DATA_W-1:0] dout_o,
  output logic                dout_oe_o,
  input  logic                tick_i,
  output logic                stat_pull_o
);
  localparam int unsigned NSYNC = 3;
  // bit 2 = wr_n, bit 1 = rd_n, bit 0 = ale
  localparam logic [NSYNC-1:0] SYNC_RST = 3'b110;

  logic [NSYNC-1:0]    sync_q;
  logic                wr_n_s, rd_n_s, ale_s, wr_n_d;
  logic                sel, wr_edge, we;
  logic [P_ADDR_W-1:0] addr_q;
  logic [P_DATA_W-1:0] rdata;
  logic                ctrl_en;

  strobe_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({wr_ni, rd_ni, ale_i}),
    .q_o (sync_q)
  );
  assign {wr_n_s, rd_n_s, ale_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_n_d <= 1'b1;
    else         wr_n_d <= wr_n_s;
  end

  assign sel     = cs1_i & ~cs0_ni;
  assign wr_edge = wr_n_s & ~wr_n_d;
  assign we      = wr_edge & sel;

  addr_latch #(.ADDR_W(P_ADDR_W)) u_latch (
    .clk_i, .rst_ni,
    .ale_i  (ale_s),
    .cs0_ni (cs0_ni),
    .addr_i (addr_i),
    .addr_o (addr_q)
  );

  reg_file #(
    .DATA_W(P_DATA_W), .ADDR_W(P_ADDR_W),
    .CTRL_ADDR(P_CTRL_ADDR), .CTRL_BIT(P_CTRL_BIT)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i      (we),
    .addr_i    (addr_q),
    .wdata_i   (din_i),
    .rdata_o   (rdata),
    .ctrl_en_o (ctrl_en)
  );

  // read suppressed while write strobe is also low
  assign dout_oe_o = sel & ~rd_n_s & wr_n_s;
  assign dout_o    = dout_oe_o ? rdata : '0;

  status_gate u_stat (
    .clk_i, .rst_ni,
    .tick_i (tick_i),
    .en_i   (ctrl_en),
    .pull_o (stat_pull_o)
  );

  AST_RD_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_oe_o |-> !$past(rd_ni, 2)) else $error("drive without read"); // R6
  AST_RD_WR_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_oe_o |-> $past(wr_ni, 2)) else $error("drive during write"); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dout_oe_o |-> dout_o == '0) else $error("data not released"); // R6
endmodule

// File: tb/tb_nibble_reg_port.sv
module tb_nibble_reg_port;
  localparam int unsigned CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0, din = '0;
  logic       ale = 1'b0, cs0_n = 1'b1, cs1 = 1'b0, wr_n = 1'b1, rd_n = 1'b1, tick = 1'b0;
  logic [3:0] dout;
  logic       dout_oe, stat;

  int unsigned n_chk = 0, n_fail = 0;
  logic [3:0]  model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_reg_port dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ale_i(ale), .cs0_ni(cs0_n),
    .cs1_i(cs1), .wr_ni(wr_n), .rd_ni(rd_n), .din_i(din), .dout_o(dout),
    .dout_oe_o(dout_oe), .tick_i(tick), .stat_pull_o(stat)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch_addr(input logic [3:0] a);
    cs0_n = 1'b0; addr = a; ale = 1'b1;
    wait_n(4);
    ale = 1'b0;
    wait_n(4);
    addr = ~a;  // later bus traffic must not disturb the latch
  endtask

  task automatic write_cyc(input logic [3:0] d, input logic c0n, input logic c1);
    cs0_n = c0n; cs1 = c1; din = d; wr_n = 1'b0;
    wait_n(4);
    wr_n = 1'b1;
    wait_n(5);
    cs1 = 1'b0; cs0_n = 1'b0;
  endtask

  task automatic read_chk(input logic [3:0] exp, input string req);
    cs0_n = 1'b0; cs1 = 1'b1; rd_n = 1'b0;
    wait_n(4);
    chk(dout_oe == 1'b1, req, dout_oe, 1);
    chk(dout == exp, req, dout, exp);
    rd_n = 1'b1;
    wait_n(4);
    chk(dout_oe == 1'b0 && dout == 4'h0, "R6", dout_oe, 0);
    cs1 = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    wait_n(3);
    // R1 reset state
    chk(dout_oe == 1'b0, "R1", dout_oe, 0);
    chk(stat == 1'b0, "R1", stat, 0);
    rst_n = 1'b1;
    wait_n(2);
    for (int i = 0; i < 16; i++) begin
      latch_addr(4'(i));
      read_chk(4'h0, "R1");
    end

    // R2/R4 sweep: distinct pattern per register, written then read back
    for (int i = 0; i < 16; i++) begin
      latch_addr(4'(i));
      model[i] = 4'((i * 7 + 3) % 16);
      write_cyc(model[i], 1'b0, 1'b1);
    end
    for (int i = 15; i >= 0; i--) begin
      latch_addr(4'(i));
      read_chk(model[i], "R2 R4");
    end

    // R5: writes with either chip select inactive are ignored
    latch_addr(4'h5);
    write_cyc(~model[5], 1'b0, 1'b0);
    read_chk(model[5], "R5 cs1 low");
    write_cyc(~model[5], 1'b1, 1'b1);
    read_chk(model[5], "R5 cs0 high");

    // R3: ALE high with cs0 high must not move the latch
    latch_addr(4'h2);
    cs0_n = 1'b1; addr = 4'h9; ale = 1'b1;
    wait_n(4);
    ale = 1'b0;
    wait_n(4);
    read_chk(model[2], "R3");

    // R7: overlapping read and write strobes leave the port released
    latch_addr(4'h6);
    cs0_n = 1'b0; cs1 = 1'b1; din = model[6]; wr_n = 1'b0; rd_n = 1'b0;
    wait_n(4);
    chk(dout_oe == 1'b0, "R7", dout_oe, 0);
    chk(dout == 4'h0, "R7", dout, 0);
    rd_n = 1'b1;
    wait_n(4);
    wr_n = 1'b1;
    wait_n(5);
    cs1 = 1'b0;
    read_chk(model[6], "R7 data intact");

    // R9: ALE held high gives a transparent latch
    cs0_n = 1'b0; ale = 1'b1;
    for (int i = 0; i < 16; i += 3) begin
      addr = 4'(i);
      wait_n(4);
      read_chk(model[i], "R9 read");
    end
    addr = 4'h8;
    wait_n(4);
    model[8] = 4'hA;
    write_cyc(4'hA, 1'b0, 1'b1);
    addr = 4'h8;
    read_chk(4'hA, "R9 write");
    ale = 1'b0;
    wait_n(4);

    // R8: status gate, chip selects inactive throughout
    latch_addr(4'hD);
    model[13] = 4'h0;
    write_cyc(4'h0, 1'b0, 1'b1);
    cs0_n = 1'b1; cs1 = 1'b0;
    tick = 1'b1; wait_n(1);
    chk(stat == 1'b0, "R8 disabled", stat, 0);
    tick = 1'b0; wait_n(1);
    cs0_n = 1'b0;
    model[13] = 4'h2;
    write_cyc(4'h2, 1'b0, 1'b1);
    cs0_n = 1'b1; cs1 = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick = k[0];
      wait_n(1);
      chk(stat == k[0], "R8 enabled", stat, k[0]);
    end
    tick = 1'b0;
    wait_n(1);
    chk(stat == 1'b0, "R8 release", stat, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule